// File: doc/BRIEF.md
# Hold/Acknowledge Bus Release Controller

This controller lets an external DMA master take over the processor's off-chip program, data and I/O buses. One input pin has two uses, and a mode bit in the interrupt control register chooses between them. With the bit cleared, which is the state after reset, the pin is a bus hold request. With the bit set, the pin is a general-purpose interrupt input.

In hold mode, a request that has passed through the synchronizer does not release the bus on its own. The core must also report that it is executing its idle instruction. When both are true, the block turns off the drivers for the address bus, the data bus and the memory strobes, and raises the hold acknowledge in the same cycle. When the request goes away, the acknowledge falls first and the drivers return one cycle later. In that cycle the block sends a one-cycle pulse telling the core it may leave idle.

In interrupt mode, the bus is never released. Each rising edge of the synchronized pin sets a pending interrupt request, which stays set until the core acknowledges it.

Top module: `bus_yield_ctrl`

## Requirements
- R1: After reset, busDriveEn is 1, holdAck is 0, intReq is 0, wakeCore is 0, and the pin works as a hold request (mode bit 0).
- R2: The mode bit takes the value of cfgWrBit on a clock edge only when cfgWrEn is 1 and cfgAddr equals 16'hFFEC. A write with another address, or with cfgWrEn at 0, leaves the pin's function unchanged.
- R3: In hold mode, with coreIdle held at 1, busDriveEn goes to 0 and holdAck goes to 1 in the same cycle, on the third rising clock edge after holdIn rises. The delay is two synchronizer stages plus one state register.
- R4: In hold mode, a synchronized request seen while coreIdle is 0 stays pending and the bus stays driven. Once coreIdle is 1 at a rising edge, the bus is released at that edge.
- R5: holdAck and busDriveEn are never 1 at the same time.
- R6: After holdIn falls, holdAck drops on the third rising edge while busDriveEn is still 0. On the next edge busDriveEn returns to 1, and wakeCore is 1 for exactly that one cycle.
- R7: In interrupt mode (mode bit 1), holdIn never lowers busDriveEn and never raises holdAck, even while coreIdle is 1.
- R8: In interrupt mode, a rising edge of holdIn sets intReq on the third rising clock edge after the pin rises. A level held high produces only one request.
- R9: Once set, intReq stays at 1 until intAck is 1 at a rising edge, and is 0 from the following cycle.
- R10: In hold mode, edges on holdIn never set intReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 16 | Register write address (ADDR_W) |
| cfgWrBit | input | 1 | Value written to the mode bit |
| holdIn | input | 1 | Shared hold-request / interrupt pin, asynchronous, active high |
| coreIdle | input | 1 | Core is executing its idle instruction |
| intAck | input | 1 | Core acknowledges the pending interrupt |
| busDriveEn | output | 1 | 1: drive address, data and memory strobes; 0: high impedance |
| holdAck | output | 1 | Bus has been handed to the external master |
| intReq | output | 1 | Pending general interrupt request |
| wakeCore | output | 1 | One-cycle pulse: core may leave idle |

## Verification
The assertions check, on every cycle, that the acknowledge and the drivers are never active together and that the acknowledge only rises in hold mode after the core was idle. They also check that the acknowledge falls while the drivers are still off, that the drivers come back only together with the wake pulse, and that a pending interrupt persists until acknowledged. The bench scenarios cover what depends on exact timing and history. These are the three-edge latency through the synchronizer, a request held pending until idle, the address decode of the mode write, the single interrupt produced by a held level, and the absence of interrupts in hold mode.

// File: rtl/byc_pkg.sv
package byc_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_RELEASED = 2'd1,
    ST_DROP     = 2'd2,
    ST_REARM    = 2'd3
  } yieldState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic releaseBus;  // float drivers, raise acknowledge
    logic dropAck;     // lower acknowledge, drivers stay off
    logic restoreBus;  // drivers on, start wake pulse
    logic endWake;     // finish wake pulse
    logic raiseInt;    // set pending interrupt
  } yieldStrobe_t;

endpackage

// File: rtl/byc_datapath.sv
module byc_datapath
  import byc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] CFG_ADDR    = 16'hFFEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrBit,
  input  logic              holdIn,
  input  logic              intAck,
  input  yieldStrobe_t      strobe,
  output logic              holdSync,
  output logic              holdEdge,
  output logic              holdMode,
  output logic              busDriveEn,
  output logic              holdAck,
  output logic              intReq,
  output logic              wakeCore
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(CFG_ADDR);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncPrev;
  logic                   modeBit;

  // synchronizer chain
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN)       syncQ[g] <= 1'b0;
      else if (g == 0) syncQ[g] <= holdIn;
      else             syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
    end
  end

  assign holdSync = syncQ[LAST];
  assign holdEdge = holdSync & ~syncPrev;
  assign holdMode = ~modeBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncPrev <= 1'b0;
      modeBit  <= 1'b0;
    end else begin
      syncPrev <= holdSync;
      if (cfgWrEn && cfgAddr == MODE_ADDR) modeBit <= cfgWrBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busDriveEn <= 1'b1;
      holdAck    <= 1'b0;
      wakeCore   <= 1'b0;
      intReq     <= 1'b0;
    end else begin
      if (strobe.releaseBus) begin
        busDriveEn <= 1'b0;
        holdAck    <= 1'b1;
      end
      if (strobe.dropAck) holdAck <= 1'b0;
      if (strobe.restoreBus) begin
        busDriveEn <= 1'b1;
        wakeCore   <= 1'b1;
      end
      if (strobe.endWake) wakeCore <= 1'b0;
      // a new edge wins over an acknowledge in the same cycle
      if (strobe.raiseInt)  intReq <= 1'b1;
      else if (intAck)      intReq <= 1'b0;
    end
  end

endmodule

// File: rtl/byc_control.sv
module byc_control
  import byc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         holdSync,
  input  logic         holdEdge,
  input  logic         holdMode,
  input  logic         coreIdle,
  output yieldStrobe_t strobe
);

  yieldState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    strobe.raiseInt = ~holdMode & holdEdge;
    unique case (stateQ)
      ST_RUN: begin
        if (holdMode && holdSync && coreIdle) begin
          strobe.releaseBus = 1'b1;
          stateNext = ST_RELEASED;
        end
      end
      ST_RELEASED: begin
        if (!holdSync) begin
          strobe.dropAck = 1'b1;
          stateNext = ST_DROP;
        end
      end
      ST_DROP: begin
        strobe.restoreBus = 1'b1;
        stateNext = ST_REARM;
      end
      ST_REARM: begin
        strobe.endWake = 1'b1;
        stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateNext;
  end

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
  import byc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] CFG_ADDR    = 16'hFFEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrBit,
  input  logic              holdIn,
  input  logic              coreIdle,
  input  logic              intAck,
  output logic              busDriveEn,
  output logic              holdAck,
  output logic              intReq,
  output logic              wakeCore
);

  yieldStrobe_t strobe;
  logic holdSync, holdEdge, holdMode;

  byc_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrBit(cfgWrBit), .holdIn(holdIn), .intAck(intAck), .strobe(strobe),
    .holdSync(holdSync), .holdEdge(holdEdge), .holdMode(holdMode),
    .busDriveEn(busDriveEn), .holdAck(holdAck), .intReq(intReq),
    .wakeCore(wakeCore)
  );

  byc_control u_ctl (
    .clk(clk), .rstN(rstN), .holdSync(holdSync), .holdEdge(holdEdge),
    .holdMode(holdMode), .coreIdle(coreIdle), .strobe(strobe)
  );

endmodule

// File: rtl/bus_yield_ctrl_chk.sv
module bus_yield_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic holdMode,
  input logic coreIdle,
  input logic intAck,
  input logic busDriveEn,
  input logic holdAck,
  input logic intReq,
  input logic wakeCore
);

  assert_ack_drive_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> !busDriveEn);

  assert_release_needs_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(coreIdle));

  assert_release_only_hold_mode_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> $past(holdMode));

  assert_ack_falls_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdAck) |-> !busDriveEn);

  assert_drive_returns_with_wake_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busDriveEn) |-> wakeCore);

  assert_wake_one_cycle_R6: assert property (@(posedge clk) disable iff (!rstN)
    wakeCore |=> !wakeCore);

  assert_int_held_until_ack_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !intAck) |=> intReq);

endmodule

bind bus_yield_ctrl bus_yield_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .holdMode(holdMode), .coreIdle(coreIdle),
  .intAck(intAck), .busDriveEn(busDriveEn), .holdAck(holdAck),
  .intReq(intReq), .wakeCore(wakeCore)
);

// File: tb/bus_yield_ctrl_bench.sv
module bus_yield_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [15:0] cfgAddr = 16'h0000;
  logic cfgWrBit = 1'b0;
  logic holdIn = 1'b0;
  logic coreIdle = 1'b0;
  logic intAck = 1'b0;
  logic busDriveEn, holdAck, intReq, wakeCore;

  always #2.5 clk = ~clk;  // 200 MHz

  bus_yield_ctrl u_bus_yield_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrBit(cfgWrBit), .holdIn(holdIn), .coreIdle(coreIdle),
    .intAck(intAck), .busDriveEn(busDriveEn), .holdAck(holdAck),
    .intReq(intReq), .wakeCore(wakeCore)
  );

  typedef struct {
    logic  drv, ack, irq, wake;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectOut(input logic d, input logic a, input logic i,
                           input logic w, input string tag);
    expItem_t it;
    it.drv = d; it.ack = a; it.irq = i; it.wake = w; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic writeMode(input logic [15:0] addr, input logic en, input logic val);
    cfgAddr = addr; cfgWrEn = en; cfgWrBit = val;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  // monitor: compares shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        compared++;
        if ({busDriveEn, holdAck, intReq, wakeCore} !== {it.drv, it.ack, it.irq, it.wake}) begin
          mismatched++;
          $display("FAIL %s: drv/ack/irq/wake actual=%b%b%b%b expected=%b%b%b%b",
                   it.tag, busDriveEn, holdAck, intReq, wakeCore,
                   it.drv, it.ack, it.irq, it.wake);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectOut(1, 0, 0, 0, "R1 reset state");

    // R3 / R10: release with core idle
    coreIdle = 1'b1; holdIn = 1'b1;
    tick(2);
    expectOut(1, 0, 0, 0, "R3 not yet released after two edges");
    tick(1);
    expectOut(0, 1, 0, 0, "R3 released on third edge, R10 no interrupt");

    // R6: restore ordering
    holdIn = 1'b0;
    tick(2);
    expectOut(0, 1, 0, 0, "R6 still released");
    tick(1);
    expectOut(0, 0, 0, 0, "R6 ack drops, drivers off");
    tick(1);
    expectOut(1, 0, 0, 1, "R6 drivers back with wake");
    tick(1);
    expectOut(1, 0, 0, 0, "R6 wake is one cycle");

    // R4: pending until idle
    coreIdle = 1'b0; holdIn = 1'b1;
    tick(5);
    expectOut(1, 0, 0, 0, "R4 held pending without idle");
    coreIdle = 1'b1;
    tick(1);
    expectOut(0, 1, 0, 0, "R4 released once idle");
    holdIn = 1'b0;
    tick(5);
    expectOut(1, 0, 0, 0, "R6 back to run");

    // R2: write to another address is ignored
    writeMode(16'hFFED, 1'b1, 1'b1);
    holdIn = 1'b1;
    tick(3);
    expectOut(0, 1, 0, 0, "R2 wrong address keeps hold mode");
    holdIn = 1'b0;
    tick(5);
    expectOut(1, 0, 0, 0, "R2 run after release");

    // R7 / R8: interrupt mode
    writeMode(16'hFFEC, 1'b1, 1'b1);
    holdIn = 1'b1;
    tick(2);
    expectOut(1, 0, 0, 0, "R8 not before third edge");
    tick(1);
    expectOut(1, 0, 1, 0, "R8 interrupt on third edge");
    tick(5);
    expectOut(1, 0, 1, 0, "R7 no release in interrupt mode, R9 held");
    intAck = 1'b1;
    tick(1);
    intAck = 1'b0;
    expectOut(1, 0, 0, 0, "R9 cleared by ack");
    tick(4);
    expectOut(1, 0, 0, 0, "R8 held level gives one request");
    holdIn = 1'b0;
    tick(4);
    holdIn = 1'b1;
    tick(3);
    expectOut(1, 0, 1, 0, "R8 second edge second request");
    tick(3);
    expectOut(1, 0, 1, 0, "R9 pending without ack");
    intAck = 1'b1;
    tick(1);
    intAck = 1'b0;
    holdIn = 1'b0;
    expectOut(1, 0, 0, 0, "R9 cleared again");

    // R2: write with strobe low is ignored
    tick(3);
    writeMode(16'hFFEC, 1'b0, 1'b0);
    holdIn = 1'b1;
    tick(3);
    expectOut(1, 0, 1, 0, "R2 strobe low keeps interrupt mode");
    intAck = 1'b1;
    tick(1);
    intAck = 1'b0;
    holdIn = 1'b0;
    tick(3);

    // R2: proper write returns to hold mode
    writeMode(16'hFFEC, 1'b1, 1'b0);
    holdIn = 1'b1;
    tick(3);
    expectOut(0, 1, 0, 0, "R2 hold mode restored, R10 no interrupt");
    holdIn = 1'b0;
    tick(5);
    expectOut(1, 0, 0, 0, "R6 final run");

    tick(2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule